// File: doc/BRIEF.md
# SPI-Mode Storage Card Byte Responder

This block is the byte-level protocol layer of a storage card that is accessed over SPI. An external shift register delivers one received byte per exchange on `mosi_byte` with `byte_valid` high. The block answers in the same cycle on `miso_byte`. It frames the command index and its argument, then fires one request at a command engine, which answers combinationally in that cycle. The block turns the engine's 32-bit card status into the SPI-mode status word and sends that word as one, two or five bytes, depending on the command. When the engine has read data waiting, the block sends a start token and then streams the data bytes. A stop byte that arrives during a read ends the stream and starts a new command. The first response slot after it is always left idle.

The controller has five named states. `ST_CMD` waits for a command byte: an all-ones byte keeps it there, and any other byte moves it to `ST_ARG`. `ST_ARG` gathers the argument bytes and the check byte, then moves to `ST_RESP` when it executes the command. `ST_RESP` sends the response bytes. After them it moves to `ST_DSTART` if data is pending, or back to `ST_CMD` if not. `ST_DSTART` sends the token and moves to `ST_DREAD`. `ST_DREAD` moves back to `ST_CMD` after the last data byte, or moves to `ST_ARG` on a stop byte.

Top module: `sd_spi_byte_responder`

## Requirements
- R1: After reset the block is in the command state. `miso_byte` reads 0xFF whenever `byte_valid` is low.
- R2: In the command state, a received 0xFF is answered with 0xFF, and the block stays in the command state.
- R3: Any other byte in the command state sets the command index from its bits 5:0. The next four bytes form the argument, most significant first. The fifth byte is ignored and causes exactly one `eng_req` pulse carrying that index and argument. Every byte of this phase is answered with 0xFF.
- R4: When the engine reports a response length of 0, the response is the single byte 0x04.
- R5: When the engine reports a response length other than 0 or 4, the response is the single byte 0x04, except in the case R6 covers.
- R6: Command 58 with a nonzero response length is answered with 0x01 followed by the four bytes of `eng_rsp_word`, most significant first.
- R7: Command 13 is answered with both bytes of the 16-bit status word, high byte first. Every other command with a length-4 response sends only the high byte.
- R8: In the status word, bit 8 is set when card-status bits 12:9 are below 4. The other bits map from card-status bits as follows: bit 9 from 13, bit 10 from 22, bit 11 from 23, bit 12 from 28 and bit 13 from 30. In the low byte, bit 0 comes from 25, bit 1 from 24 or 15, bit 2 from 19, bit 3 from 20, bit 4 from 21, bit 5 from 26, bit 6 from 27 and bit 7 from 31 or 16. Bit 15 is 0.
- R9: Bit 14 of the status word is set whenever any bit of its low byte is set.
- R10: After the response bytes, if `eng_data_avail` is high, the block sends 0xFF, then 0xFE, then one `eng_rd_data` byte per exchange, popping each byte. It returns to the command state after the byte flagged by `eng_rd_last`.
- R11: After the response bytes, if no data is pending, the next byte is answered with 0xFF and the block returns to the command state.
- R12: A 0x4D received during the data stream is answered with 0xFF and pops no data. It starts a new command with index 13. The first response slot that follows is filled with 0xFF before the response bytes are sent.
- R13: A reset in the middle of a command clears the argument count, so the next command is framed from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | One byte exchange takes place this cycle |
| mosi_byte | input | 8 | Byte received from the host |
| miso_byte | output | 8 | Reply byte for this exchange |
| eng_req | output | 1 | Execute request to the command engine |
| eng_cmd | output | 6 | Command index of the request |
| eng_arg | output | 32 | Command argument |
| eng_rsp_len | input | 5 | Engine response length in bytes (0 = none) |
| eng_rsp_word | input | 32 | Engine response: card status or OCR |
| eng_data_avail | input | 1 | Read data is pending in the engine |
| eng_rd_pop | output | 1 | Consume one read data byte |
| eng_rd_data | input | 8 | Current read data byte |
| eng_rd_last | input | 1 | Current read data byte is the last one |

## Verification
Every reply is produced in the same cycle as its exchange. The bench therefore drives each byte just after a falling edge and reads `miso_byte` 2 ns later, before the rising edge that closes the exchange. State changes take effect at that rising edge, so each one is checked on the following exchange. The `eng_req` argument is captured at the rising edge of the check byte and compared once that edge has passed. The response to a command starts on the exchange right after its check byte, or one exchange later after a stop byte. The data token then follows exactly one idle byte after the last response byte.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ARG,
        ST_RESP,
        ST_DSTART,
        ST_DREAD
    } sdspi_state_e;

    localparam logic [7:0] IDLE_BYTE    = 8'hFF;
    localparam logic [7:0] DATA_TOKEN   = 8'hFE;
    localparam logic [7:0] ABORT_BYTE   = 8'h4D;
    localparam logic [7:0] REJECT_BYTE  = 8'h04;
    localparam logic [7:0] OCR_LEAD     = 8'h01;
    localparam logic [5:0] CMD_OCR      = 6'd58;
    localparam logic [5:0] CMD_STATUS   = 6'd13;

    // card-status bit positions
    localparam int CS_OUT_RANGE   = 31;
    localparam int CS_ADDR_ERR    = 30;
    localparam int CS_ESEQ_ERR    = 28;
    localparam int CS_EPARAM      = 27;
    localparam int CS_WP_VIOL     = 26;
    localparam int CS_LOCKED      = 25;
    localparam int CS_LOCK_FAIL   = 24;
    localparam int CS_CRC_ERR     = 23;
    localparam int CS_ILLEGAL     = 22;
    localparam int CS_ECC_FAIL    = 21;
    localparam int CS_CC_ERR      = 20;
    localparam int CS_GEN_ERR     = 19;
    localparam int CS_CSD_OVWR    = 16;
    localparam int CS_WP_SKIP     = 15;
    localparam int CS_ERST        = 13;
    localparam int CS_STATE_LSB   = 9;
    localparam int CS_STATE_W     = 4;

endpackage

// File: rtl/sdspi_status_map.sv
module sdspi_status_map
    import sdspi_pkg::*;
(
    input  logic [31:0] card_status,
    output logic [15:0] spi_status
);
    logic [CS_STATE_W-1:0] cur_phase;
    logic [7:0]            low_b;

    assign cur_phase = card_status[CS_STATE_LSB +: CS_STATE_W];

    always_comb begin
        low_b[0] = card_status[CS_LOCKED];
        low_b[1] = card_status[CS_LOCK_FAIL] | card_status[CS_WP_SKIP];
        low_b[2] = card_status[CS_GEN_ERR];
        low_b[3] = card_status[CS_CC_ERR];
        low_b[4] = card_status[CS_ECC_FAIL];
        low_b[5] = card_status[CS_WP_VIOL];
        low_b[6] = card_status[CS_EPARAM];
        low_b[7] = card_status[CS_OUT_RANGE] | card_status[CS_CSD_OVWR];
    end

    always_comb begin
        spi_status       = '0;
        spi_status[7:0]  = low_b;
        spi_status[8]    = (cur_phase < CS_STATE_W'(4));
        spi_status[9]    = card_status[CS_ERST];
        spi_status[10]   = card_status[CS_ILLEGAL];
        spi_status[11]   = card_status[CS_CRC_ERR];
        spi_status[12]   = card_status[CS_ESEQ_ERR];
        spi_status[13]   = card_status[CS_ADDR_ERR];
        spi_status[14]   = |low_b;
    end

endmodule

// File: rtl/sdspi_resp_builder.sv
module sdspi_resp_builder
    import sdspi_pkg::*;
#(
    parameter int RESP_MAX = 5,
    parameter int RLEN_W   = 5,
    localparam int RCNT_W  = $clog2(RESP_MAX + 1)
) (
    input  logic [5:0]                cmd_idx,
    input  logic [RLEN_W-1:0]         rsp_len,
    input  logic [31:0]               rsp_word,
    output logic [RESP_MAX-1:0][7:0]  rsp_bytes,
    output logic [RCNT_W-1:0]         rsp_cnt
);
    // RESP_MAX must be at least 5 to hold the OCR frame
    logic [15:0] spi_status;

    sdspi_status_map u_map (
        .card_status (rsp_word),
        .spi_status  (spi_status)
    );

    always_comb begin
        rsp_bytes    = '0;
        rsp_bytes[0] = REJECT_BYTE;
        rsp_cnt      = RCNT_W'(1);
        if (rsp_len == '0) begin
            rsp_bytes[0] = REJECT_BYTE;
        end else if (cmd_idx == CMD_OCR) begin
            rsp_cnt      = RCNT_W'(5);
            rsp_bytes[0] = OCR_LEAD;
            for (int k = 1; k < 5; k++) begin
                rsp_bytes[k] = rsp_word[8*(4-k) +: 8];
            end
        end else if (rsp_len == RLEN_W'(4)) begin
            rsp_cnt      = (cmd_idx == CMD_STATUS) ? RCNT_W'(2) : RCNT_W'(1);
            rsp_bytes[0] = spi_status[15:8];
            rsp_bytes[1] = spi_status[7:0];
        end
    end

endmodule

// File: rtl/sd_spi_byte_responder.sv
module sd_spi_byte_responder
    import sdspi_pkg::*;
#(
    parameter int ARG_BYTES = 4,
    parameter int RESP_MAX  = 5,
    parameter int RLEN_W    = 5,
    localparam int ARG_W    = 8 * ARG_BYTES,
    localparam int ACNT_W   = $clog2(ARG_BYTES + 1),
    localparam int RCNT_W   = $clog2(RESP_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        mosi_byte,
    output logic [7:0]        miso_byte,
    output logic              eng_req,
    output logic [5:0]        eng_cmd,
    output logic [ARG_W-1:0]  eng_arg,
    input  logic [RLEN_W-1:0] eng_rsp_len,
    input  logic [31:0]       eng_rsp_word,
    input  logic              eng_data_avail,
    output logic              eng_rd_pop,
    input  logic [7:0]        eng_rd_data,
    input  logic              eng_rd_last
);
    localparam logic [ACNT_W-1:0] ARG_FULL = ACNT_W'(ARG_BYTES);

    sdspi_state_e             state_q, state_d;
    logic [5:0]               cmd_q;
    logic [ARG_W-1:0]         arg_q;
    logic [ACNT_W-1:0]        arg_cnt_q;
    logic [RESP_MAX-1:0][7:0] resp_q;
    logic [RCNT_W-1:0]        resp_cnt_q;
    logic [RCNT_W-1:0]        resp_pos_q;
    logic                     gap_q;

    logic [RESP_MAX-1:0][7:0] bld_bytes;
    logic [RCNT_W-1:0]        bld_cnt;
    logic                     abort_hit;
    logic                     resp_done;

    assign eng_cmd   = cmd_q;
    assign eng_arg   = arg_q;
    assign abort_hit = (state_q == ST_DREAD) && (mosi_byte == ABORT_BYTE);
    assign resp_done = (resp_pos_q >= resp_cnt_q);

    sdspi_resp_builder #(
        .RESP_MAX (RESP_MAX),
        .RLEN_W   (RLEN_W)
    ) u_build (
        .cmd_idx   (cmd_q),
        .rsp_len   (eng_rsp_len),
        .rsp_word  (eng_rsp_word),
        .rsp_bytes (bld_bytes),
        .rsp_cnt   (bld_cnt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        miso_byte  = IDLE_BYTE;
        eng_req    = 1'b0;
        eng_rd_pop = 1'b0;
        if (byte_valid) begin
            unique case (state_q)
                ST_CMD: begin
                    if (mosi_byte != IDLE_BYTE) state_d = ST_ARG;
                end
                ST_ARG: begin
                    if (arg_cnt_q == ARG_FULL) begin
                        eng_req = 1'b1;
                        state_d = ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (!gap_q) begin
                        if (resp_done)
                            state_d = eng_data_avail ? ST_DSTART : ST_CMD;
                        else
                            miso_byte = resp_q[resp_pos_q];
                    end
                end
                ST_DSTART: begin
                    miso_byte = DATA_TOKEN;
                    state_d   = ST_DREAD;
                end
                ST_DREAD: begin
                    if (abort_hit) begin
                        state_d = ST_ARG;
                    end else begin
                        miso_byte  = eng_rd_data;
                        eng_rd_pop = 1'b1;
                        if (eng_rd_last) state_d = ST_CMD;
                    end
                end
                default: state_d = ST_CMD;
            endcase
        end
    end

    // framing and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            arg_q      <= '0;
            arg_cnt_q  <= '0;
            resp_q     <= '0;
            resp_cnt_q <= '0;
            resp_pos_q <= '0;
            gap_q      <= 1'b0;
        end else if (byte_valid) begin
            unique case (state_q)
                ST_CMD: begin
                    if (mosi_byte != IDLE_BYTE) begin
                        cmd_q     <= mosi_byte[5:0];
                        arg_cnt_q <= '0;
                    end
                end
                ST_ARG: begin
                    if (arg_cnt_q == ARG_FULL) begin
                        resp_q     <= bld_bytes;
                        resp_cnt_q <= bld_cnt;
                        resp_pos_q <= '0;
                    end else begin
                        arg_q     <= {arg_q[ARG_W-9:0], mosi_byte};
                        arg_cnt_q <= arg_cnt_q + 1'b1;
                    end
                end
                ST_RESP: begin
                    if (gap_q)           gap_q      <= 1'b0;
                    else if (!resp_done) resp_pos_q <= resp_pos_q + 1'b1;
                end
                ST_DREAD: begin
                    if (abort_hit) begin
                        cmd_q     <= mosi_byte[5:0];
                        arg_cnt_q <= '0;
                        gap_q     <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    null_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && state_q == ST_CMD && mosi_byte == IDLE_BYTE) |=> (state_q == ST_CMD));

    // R3
    exec_enter_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> (state_q == ST_RESP && resp_pos_q == '0));

    // R6
    ocr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_cmd == CMD_OCR && eng_rsp_len != '0) |=> (resp_cnt_q == RCNT_W'(5)));

    // R10
    token_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && state_q == ST_DSTART) |=> (state_q == ST_DREAD));

    // R12
    abort_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && abort_hit) |=> (state_q == ST_ARG && gap_q && cmd_q == CMD_STATUS));

    // R7
    resp_pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_pos_q <= resp_cnt_q));

endmodule

// File: tb/sd_spi_byte_responder_bench.sv
module sd_spi_byte_responder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  mosi_byte = 8'hFF;
    logic [7:0]  miso_byte;
    logic        eng_req;
    logic [5:0]  eng_cmd;
    logic [31:0] eng_arg;
    logic [4:0]  eng_rsp_len = 5'd4;
    logic [31:0] eng_rsp_word = 32'h0;
    logic        eng_data_avail;
    logic        eng_rd_pop;
    logic [7:0]  eng_rd_data;
    logic        eng_rd_last;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench-side engine model
    logic [7:0] rd_mem [0:7];
    int         rd_count = 0;
    bit         load_tgl = 1'b0;
    bit         load_seen = 1'b0;
    bit         rd_live = 1'b0;
    int         rd_idx = 0;
    int         req_cnt = 0;
    logic [5:0] last_cmd = '0;
    logic [31:0] last_arg = '0;

    always #10 clk = ~clk;

    assign eng_data_avail = rd_live && (rd_idx < rd_count);
    assign eng_rd_data    = (rd_idx < 8) ? rd_mem[rd_idx] : 8'h00;
    assign eng_rd_last    = (rd_idx == rd_count - 1);

    always @(posedge clk) begin
        if (load_tgl != load_seen) begin
            load_seen <= load_tgl;
            rd_idx    <= 0;
            rd_live   <= 1'b1;
        end else if (eng_rd_pop) begin
            rd_idx <= rd_idx + 1;
        end
        if (eng_req) begin
            req_cnt  <= req_cnt + 1;
            last_cmd <= eng_cmd;
            last_arg <= eng_arg;
            if (eng_cmd == 6'd13) rd_live <= 1'b0;
        end
    end

    sd_spi_byte_responder u_sd_spi_byte_responder (
        .clk            (clk),
        .rst_n          (rst_n),
        .byte_valid     (byte_valid),
        .mosi_byte      (mosi_byte),
        .miso_byte      (miso_byte),
        .eng_req        (eng_req),
        .eng_cmd        (eng_cmd),
        .eng_arg        (eng_arg),
        .eng_rsp_len    (eng_rsp_len),
        .eng_rsp_word   (eng_rsp_word),
        .eng_data_avail (eng_data_avail),
        .eng_rd_pop     (eng_rd_pop),
        .eng_rd_data    (eng_rd_data),
        .eng_rd_last    (eng_rd_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b, input logic [7:0] exp, input string tag);
        logic [7:0] r;
        @(negedge clk);
        byte_valid = 1'b1;
        mosi_byte  = b;
        #2 r = miso_byte;
        @(posedge clk);
        #1 byte_valid = 1'b0;
        chk(tag, {24'h0, r}, {24'h0, exp});
    endtask

    task automatic send_cmd(input logic [7:0] c, input logic [31:0] a);
        xfer(c, 8'hFF, "R3 cmd byte");
        for (int i = 3; i >= 0; i--) xfer(a[8*i +: 8], 8'hFF, "R3 arg byte");
        xfer(8'h95, 8'hFF, "R3 check byte");
    endtask

    // {mosi, expected miso}; engine: length 4, status 0x0040_0600
    localparam logic [15:0] VEC [0:19] = '{
        16'hFF_FF, 16'h4D_FF, 16'h00_FF, 16'h00_FF, 16'h00_FF,
        16'h00_FF, 16'h95_FF, 16'hFF_05, 16'hFF_00, 16'hFF_FF,
        16'hFF_FF, 16'h40_FF, 16'h00_FF, 16'h00_FF, 16'h00_FF,
        16'h00_FF, 16'h95_FF, 16'hFF_05, 16'hFF_FF, 16'hFF_FF
    };

    initial begin
        for (int i = 0; i < 8; i++) rd_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 idle reply after reset", {24'h0, miso_byte}, 32'hFF);
        rst_n = 1'b1;
        @(posedge clk);

        // table walk: R2 null, R3 framing, R7 lengths, R8 idle/illegal, R11 end
        eng_rsp_len  = 5'd4;
        eng_rsp_word = 32'h0040_0600;
        for (int i = 0; i < 20; i++)
            xfer(VEC[i][15:8], VEC[i][7:0], "R2/R7/R8/R11 table");

        // R3 argument order and index masking
        begin
            int base;
            base = req_cnt;
            send_cmd(8'hD1, 32'h1234_5678);
            chk("R3 one request", req_cnt - base, 1);
            chk("R3 index low bits", {26'h0, last_cmd}, 32'd17);
            chk("R3 argument msb first", last_arg, 32'h1234_5678);
            xfer(8'hFF, 8'h05, "R7 single byte");
            xfer(8'hFF, 8'hFF, "R11 end");
        end

        // R4 no response
        eng_rsp_len = 5'd0;
        send_cmd(8'h41, 32'h0);
        xfer(8'hFF, 8'h04, "R4 no response");
        xfer(8'hFF, 8'hFF, "R11 end");

        // R5 unexpected size
        eng_rsp_len = 5'd6;
        send_cmd(8'h4D, 32'h0);
        xfer(8'hFF, 8'h04, "R5 odd size");
        xfer(8'hFF, 8'hFF, "R5 one byte only");

        // R6 OCR frame
        eng_rsp_len  = 5'd4;
        eng_rsp_word = 32'h80FF_8000;
        send_cmd(8'h7A, 32'h0);
        xfer(8'hFF, 8'h01, "R6 lead");
        xfer(8'hFF, 8'h80, "R6 ocr b3");
        xfer(8'hFF, 8'hFF, "R6 ocr b2");
        xfer(8'hFF, 8'h80, "R6 ocr b1");
        xfer(8'hFF, 8'h00, "R6 ocr b0");
        xfer(8'hFF, 8'hFF, "R11 end");

        // R8 + R9 low byte and parameter bit
        eng_rsp_word = 32'h8200_2A00;
        send_cmd(8'h4D, 32'h0);
        xfer(8'hFF, 8'h42, "R9 high byte with param");
        xfer(8'hFF, 8'h81, "R8 low byte");
        xfer(8'hFF, 8'hFF, "R11 end");

        // R8 upper error bits, single byte
        eng_rsp_word = 32'h5080_0000;
        send_cmd(8'h50, 32'h0000_0200);
        xfer(8'hFF, 8'h39, "R8 addr/seq/crc/idle");
        xfer(8'hFF, 8'hFF, "R11 end");

        // R10 data read
        eng_rsp_word = 32'h0000_0800;
        rd_mem[0] = 8'hA1; rd_mem[1] = 8'hB2; rd_mem[2] = 8'hC3;
        rd_count = 3;
        load_tgl = ~load_tgl;
        send_cmd(8'h51, 32'h0);
        xfer(8'hFF, 8'h00, "R10 status");
        xfer(8'hFF, 8'hFF, "R10 gap");
        xfer(8'hFF, 8'hFE, "R10 token");
        xfer(8'hFF, 8'hA1, "R10 data0");
        xfer(8'hFF, 8'hB2, "R10 data1");
        xfer(8'hFF, 8'hC3, "R10 data2");
        xfer(8'hFF, 8'hFF, "R10 back to command");
        chk("R10 bytes popped", rd_idx, 3);

        // R12 abort during read
        rd_mem[0] = 8'h11; rd_mem[1] = 8'h22; rd_mem[2] = 8'h33; rd_mem[3] = 8'h44;
        rd_count = 4;
        load_tgl = ~load_tgl;
        send_cmd(8'h51, 32'h0);
        xfer(8'hFF, 8'h00, "R10 status");
        xfer(8'hFF, 8'hFF, "R10 gap");
        xfer(8'hFF, 8'hFE, "R10 token");
        xfer(8'hFF, 8'h11, "R10 data0");
        xfer(8'h4D, 8'hFF, "R12 abort reply");
        chk("R12 no pop on abort", rd_idx, 1);
        for (int i = 0; i < 4; i++) xfer(8'h00, 8'hFF, "R12 arg");
        xfer(8'h95, 8'hFF, "R12 check byte");
        chk("R12 index 13", {26'h0, last_cmd}, 32'd13);
        xfer(8'hFF, 8'hFF, "R12 gap slot");
        xfer(8'hFF, 8'h00, "R12 status hi");
        xfer(8'hFF, 8'h00, "R12 status lo");
        xfer(8'hFF, 8'hFF, "R12 end");
        chk("R12 data left untouched", rd_idx, 1);

        // R13 reset mid-command
        eng_rsp_word = 32'h0040_0600;
        xfer(8'h51, 8'hFF, "R3 cmd byte");
        xfer(8'h00, 8'hFF, "R3 arg byte");
        xfer(8'h00, 8'hFF, "R3 arg byte");
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 idle reply in reset", {24'h0, miso_byte}, 32'hFF);
        rst_n = 1'b1;
        send_cmd(8'h4D, 32'h0000_00AB);
        chk("R13 fresh framing", last_arg, 32'h0000_00AB);
        xfer(8'hFF, 8'h05, "R13 status hi");
        xfer(8'hFF, 8'h00, "R13 status lo");
        xfer(8'hFF, 8'hFF, "R11 end");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule